// File: doc/BRIEF.md
# Receive Sample Clock Regenerator

This block produces the sampling strobe for the demodulated reader-to-tag signal of a contactless card receiver. It runs on the regenerated carrier clock. It divides that clock by a programmable ratio, so that one strobe falls in every `div_ratio` carrier cycles. A ratio of 32 at the 106 kbit/s type A rate gives four samples per bit period.

The divider does not run free. Its phase is set by the first falling edge of the receive level within a frame. The strobe is then placed a programmable number of carrier cycles after that edge, taken modulo the ratio. Later falling edges in the same frame leave the phase alone. A frame-idle input stops the strobes and re-arms the synchronisation for the next frame.

The receive level comes from a 7-bit digitised envelope sample compared with a 7-bit threshold. The level captured on each strobe is presented as the sampled data bit. A bit decoder downstream consumes the strobe and the bit.

Top module: `rxs_sample_regen`

## Requirements
- R1: After reset the block is armed and not locked, `sample_en` and `sample_bit` are 0, and no strobe is produced until a sync edge occurs.
- R2: The receive level is 1 when `env_sample >= threshold`, compared as unsigned values in the range 0 to 127, and 0 otherwise. The case `env_sample == threshold` gives 1.
- R3: A falling edge is a clock edge at which the level is 0 while it was 1 at the previous clock edge; the level held at the previous edge is 0 after reset. The first falling edge while armed and with `frame_idle` low is the sync edge. It locks the divider and clears the armed state.
- R4: Let N be the effective ratio and q = `phase_ofs` mod N. While locked and with `frame_idle` low, `sample_en` is high in the clock period that starts q + kN edges after the sync edge, for k = 0, 1, 2 and so on. The period that begins at the sync edge itself counts as offset 0.
- R5: A `div_ratio` of 0 is treated as a ratio of 1, which gives a strobe in every period once locked.
- R6: Falling edges after the sync edge do not move the strobe phase until the block is re-armed.
- R7: While `frame_idle` is high, `sample_en` is 0 and `sample_bit` holds. Each edge with `frame_idle` high re-arms the block and unlocks it. A falling edge at such an edge is not taken as a sync edge.
- R8: `sample_bit` changes only at a clock edge that ends a period with `sample_en` high. At that edge it takes the receive level.
- R9: A `phase_ofs` equal to or larger than N is reduced modulo N. For example, N=8 with offset 21 places the first strobe 5 periods after the sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Regenerated carrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_idle | input | 1 | High between frames; re-arms the sync and blocks strobes |
| env_sample | input | LVL_W (7) | Digitised envelope sample |
| threshold | input | LVL_W (7) | Comparator reference |
| div_ratio | input | DIV_W (8) | Carrier cycles per strobe; 0 acts as 1 |
| phase_ofs | input | PH_W (8) | Strobe delay after the sync edge, in carrier cycles |
| sample_en | output | 1 | Sample strobe, one period wide |
| sample_bit | output | 1 | Level captured on the last strobe |

## Verification
A re-arming `frame_idle` and a falling receive level can arrive at the same clock edge. The bench provokes this by holding the level high while idle and then dropping it in the last idle cycle. It judges the result by counting strobes over the following idle-free cycles with a constant low level: the count must stay zero. A second pairing is also exercised. Extra falling edges can land on strobe periods of a locked frame, and the per-cycle reference model confirms that the phase and period are unchanged.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   // lock state of the strobe divider
   typedef enum logic {
      ST_ARMED  = 1'b0,
      ST_LOCKED = 1'b1
   } rxs_state_e;
endpackage

// File: rtl/rxs_level_detect.sv
module rxs_level_detect #(
   parameter int LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] env_sample,
   input  logic [LVL_W-1:0] threshold,
   input  logic             capture_en,
   output logic             fall,
   output logic             sample_bit
);
   logic level;
   logic level_q;
   logic bit_q;

   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("rxs_level_detect: LVL_W must be at least 1");
      end
   endgenerate

   assign level = (env_sample >= threshold);
   assign fall  = level_q & ~level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         level_q <= level;
         if (capture_en) bit_q <= level;
      end
   end

   assign sample_bit = bit_q;
endmodule

// File: rtl/rxs_phase_reduce.sv
module rxs_phase_reduce #(
   parameter int DIV_W = 8,
   parameter int PH_W  = 8
) (
   input  logic [DIV_W-1:0] div_ratio,
   input  logic [PH_W-1:0]  phase_ofs,
   output logic [DIV_W-1:0] n_eff,
   output logic [DIV_W-1:0] phase_q
);
   logic [DIV_W-1:0] rem [0:PH_W];

   generate
      if (DIV_W < 1 || PH_W < 1) begin : g_bad_w
         $error("rxs_phase_reduce: widths must be at least 1");
      end
   endgenerate

   assign n_eff  = (div_ratio == '0) ? DIV_W'(1) : div_ratio;
   assign rem[0] = '0;

   // restoring remainder, one stage per phase bit, MSB first
   generate
      for (genvar i = 0; i < PH_W; i++) begin : g_stage
         logic [DIV_W:0] trial;
         logic           ge;
         assign trial = {rem[i], phase_ofs[PH_W-1-i]};
         assign ge    = (trial >= {1'b0, n_eff});
         assign rem[i+1] = ge ? DIV_W'(trial - {1'b0, n_eff}) : trial[DIV_W-1:0];
      end
   endgenerate

   assign phase_q = rem[PH_W];
endmodule

// File: rtl/rxs_sync_divider.sv
module rxs_sync_divider
   import rxs_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_idle,
   input  logic             fall,
   input  logic [DIV_W-1:0] n_eff,
   input  logic [DIV_W-1:0] phase_q,
   output logic             sample_en,
   output logic             locked
);
   rxs_state_e       state;
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == n_eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_ARMED;
         cnt   <= '0;
      end else if (frame_idle) begin
         state <= ST_ARMED;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_ARMED: begin
               if (fall) begin
                  state <= ST_LOCKED;
                  cnt   <= '0;
               end
            end
            ST_LOCKED: cnt <= wrap ? '0 : cnt + 1'b1;
            default:   state <= ST_ARMED;
         endcase
      end
   end

   assign locked    = (state == ST_LOCKED);
   assign sample_en = locked & ~frame_idle & (cnt == phase_q);
endmodule

// File: rtl/rxs_sample_regen.sv
module rxs_sample_regen #(
   parameter int LVL_W = 7,
   parameter int DIV_W = 8,
   parameter int PH_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_idle,
   input  logic [LVL_W-1:0] env_sample,
   input  logic [LVL_W-1:0] threshold,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic [PH_W-1:0]  phase_ofs,
   output logic             sample_en,
   output logic             sample_bit
);
   logic             fall_w;
   logic             strobe_w;
   logic             locked_w;
   logic [DIV_W-1:0] n_eff_w;
   logic [DIV_W-1:0] phase_q_w;

   rxs_level_detect #(.LVL_W(LVL_W)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .env_sample (env_sample),
      .threshold  (threshold),
      .capture_en (strobe_w),
      .fall       (fall_w),
      .sample_bit (sample_bit)
   );

   rxs_phase_reduce #(.DIV_W(DIV_W), .PH_W(PH_W)) u_phase (
      .div_ratio (div_ratio),
      .phase_ofs (phase_ofs),
      .n_eff     (n_eff_w),
      .phase_q   (phase_q_w)
   );

   rxs_sync_divider #(.DIV_W(DIV_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_idle (frame_idle),
      .fall       (fall_w),
      .n_eff      (n_eff_w),
      .phase_q    (phase_q_w),
      .sample_en  (strobe_w),
      .locked     (locked_w)
   );

   assign sample_en = strobe_w;
endmodule

// File: rtl/rxs_sample_regen_chk.sv
module rxs_sample_regen_chk #(
   parameter int LVL_W = 7,
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_idle,
   input logic [LVL_W-1:0] env_sample,
   input logic [LVL_W-1:0] threshold,
   input logic [DIV_W-1:0] div_ratio,
   input logic             sample_en,
   input logic             sample_bit,
   input logic             locked
);
   logic [DIV_W:0] gap;
   logic           seen;
   logic [DIV_W:0] n_chk;

   assign n_chk = (div_ratio == '0) ? (DIV_W+1)'(1) : {1'b0, div_ratio};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (frame_idle) begin
         seen <= 1'b0;
      end else if (sample_en) begin
         seen <= 1'b1;
         gap  <= (DIV_W+1)'(1);
      end else begin
         gap <= gap + 1'b1;
      end
   end

   p_no_strobe_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !sample_en);

   p_bit_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sample_en) |-> (sample_bit == ($past(env_sample) >= $past(threshold))));

   p_strobe_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && seen) |-> (gap == n_chk));

   p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !frame_idle) |=> locked);

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_idle |-> !sample_en);

   p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_en) |-> $stable(sample_bit));
endmodule

bind rxs_sample_regen rxs_sample_regen_chk #(.LVL_W(LVL_W), .DIV_W(DIV_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_idle (frame_idle),
   .env_sample (env_sample),
   .threshold  (threshold),
   .div_ratio  (div_ratio),
   .sample_en  (sample_en),
   .sample_bit (sample_bit),
   .locked     (locked_w)
);

// File: tb/rxs_sample_regen_test.sv
module rxs_sample_regen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_idle = 1'b0;
   logic [6:0] env_sample = '0;
   logic [6:0] threshold = 7'd64;
   logic [7:0] div_ratio = 8'd32;
   logic [7:0] phase_ofs = 8'd5;
   logic       sample_en;
   logic       sample_bit;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_tag = "R4";
   logic last_en;
   int   strobes;

   // reference model state
   bit m_locked, m_armed, m_lvl_q, m_bit;
   int m_cnt;

   always #4 clk = ~clk;

   rxs_sample_regen uut (
      .clk(clk), .rst_n(rst_n), .frame_idle(frame_idle),
      .env_sample(env_sample), .threshold(threshold),
      .div_ratio(div_ratio), .phase_ofs(phase_ofs),
      .sample_en(sample_en), .sample_bit(sample_bit)
   );

   function automatic int eff_n();
      return (div_ratio == 0) ? 1 : int'(div_ratio);
   endfunction

   function automatic int eff_q();
      return int'(phase_ofs) % eff_n();
   endfunction

   function automatic logic [6:0] env_for(bit lvl);
      if (lvl) return 7'(int'(threshold) + ($urandom % (128 - int'(threshold))));
      return 7'($urandom % int'(threshold));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step_env(bit idle, logic [6:0] ev);
      bit lvl, exp_en, fall;
      @(negedge clk);
      frame_idle = idle;
      env_sample = ev;
      #1;
      exp_en = m_locked && !idle && (m_cnt == eff_q());
      check(sample_en === exp_en, cur_tag, int'(sample_en), int'(exp_en));
      check(sample_bit === m_bit, "R8", int'(sample_bit), int'(m_bit));
      last_en = sample_en;
      if (sample_en) strobes++;
      lvl  = (ev >= threshold);
      fall = m_lvl_q && !lvl;
      if (exp_en) m_bit = lvl;
      if (idle) begin
         m_locked = 0; m_armed = 1; m_cnt = 0;
      end else if (m_armed && fall) begin
         m_locked = 1; m_armed = 0; m_cnt = 0;
      end else if (m_locked) begin
         m_cnt = (m_cnt == eff_n() - 1) ? 0 : m_cnt + 1;
      end
      m_lvl_q = lvl;
      @(posedge clk);
      #1;
   endtask

   task automatic step(bit idle, bit lvl);
      step_env(idle, env_for(lvl));
   endtask

   // sync on a fresh edge and return the offset of the first strobe
   task automatic sync_and_measure(output int ofs);
      step(0, 1);
      step(0, 0);
      ofs = -1;
      for (int k = 0; k < 300; k++) begin
         step(0, 0);
         if (last_en) begin ofs = k; break; end
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int ofs;
      void'($urandom(32'd1234));
      m_locked = 0; m_armed = 1; m_lvl_q = 0; m_bit = 0; m_cnt = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(sample_en === 1'b0, "R1", int'(sample_en), 0);
      check(sample_bit === 1'b0, "R1", int'(sample_bit), 0);
      @(posedge clk); #1;

      // R1: no strobe while never synced (constant low level)
      cur_tag = "R1";
      strobes = 0;
      repeat (40) step(0, 0);
      check(strobes == 0, "R1", strobes, 0);

      // R3 R4: N=32, phase 5
      cur_tag = "R3";
      sync_and_measure(ofs);
      check(ofs == 5, "R3", ofs, 5);
      cur_tag = "R4";
      repeat (100) step(0, ($urandom % 3) != 0);

      // R6: extra edges do not move the phase; 64 cycles hold exactly 2 strobes
      cur_tag = "R6";
      strobes = 0;
      for (int k = 0; k < 64; k++) step(0, k[0]);
      check(strobes == 2, "R6", strobes, 2);

      // R7: idle and a falling edge on the same clock edge
      cur_tag = "R7";
      strobes = 0;
      repeat (3) step(1, 1);
      step(1, 0);
      check(strobes == 0, "R7", strobes, 0);
      repeat (40) step(0, 0);
      check(strobes == 0, "R7", strobes, 0);

      // R9: phase larger than ratio
      cur_tag = "R9";
      step(1, 1);
      div_ratio = 8'd8; phase_ofs = 8'd21;
      step(1, 1);
      sync_and_measure(ofs);
      check(ofs == 5, "R9", ofs, 5);
      repeat (30) step(0, $urandom % 2);

      // R5: ratio 0 behaves as 1
      cur_tag = "R5";
      step(1, 1);
      div_ratio = 8'd0; phase_ofs = 8'd3;
      step(1, 1);
      step(0, 1);
      step(0, 0);
      strobes = 0;
      repeat (10) step(0, $urandom % 2);
      check(strobes == 10, "R5", strobes, 10);

      // R2: threshold boundary, ratio 4 phase 0
      cur_tag = "R2";
      step(1, 1);
      div_ratio = 8'd4; phase_ofs = 8'd0; threshold = 7'd40;
      step(1, 1);
      step(0, 1);
      step(0, 0);
      step_env(0, 7'd40);
      check(last_en === 1'b1, "R2", int'(last_en), 1);
      step(0, 0);
      check(sample_bit === 1'b1, "R2", int'(sample_bit), 1);
      step(0, 0);
      step(0, 0);
      step_env(0, 7'd39);
      step(0, 1);
      check(sample_bit === 1'b0, "R2", int'(sample_bit), 0);

      // random frames
      cur_tag = "R4";
      for (int f = 0; f < 40; f++) begin
         step(1, $urandom % 2);
         div_ratio = 8'($urandom % 41);
         phase_ofs = 8'($urandom);
         threshold = 7'(1 + $urandom % 126);
         repeat (1 + $urandom % 3) step(1, $urandom % 2);
         for (int k = 0; k < 30 + int'($urandom % 120); k++) step(0, ($urandom % 4) != 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule